// File: doc/BRIEF.md
# CAN Controller Sleep and Bus Wakeup Unit

This unit controls the low-power sleep state of a CAN protocol controller. Software asks for sleep by writing 1 to the sleep bit of a control register. The same bit reads back whether sleep is still in force. While asleep, the unit watches the receive line, which is already synchronised to the block clock, for a falling edge (recessive 1 to dominant 0). Such an edge raises a wakeup interrupt.

The first dominant edge sets the wakeup flag at once, but the controller is still asleep at that point. It resumes synchronous operation only on the next falling edge or when software writes 0 to the sleep bit. Until then, register writes are ignored. This includes the write that would clear the wakeup flag. Software must therefore clear the sleep bit before clearing the flag, or poll the sleep bit until it reads 0. If the block clock is gated off when the wake edge arrives, sleep ends on the first enabled cycle, with no need for a second edge.

Top module: `can_sleep_wake`

## Requirements
- R1: After reset, the control register (address 0) reads 0, the status register (address 1) reads 0, the config register (address 2) reads 0 and `wake_irq` is low.
- R2: A write with control bit 0 = 1 enters sleep only while `rx` is 1 (recessive). If `rx` is 0, control bit 0 stays 0. Control bit 1 (bus wake enable) takes the written value in either case.
- R3: While asleep with control bit 1 set, the first 1-to-0 transition of `rx` sets status bit 5 and `wake_irq` after that clock edge. Control bit 0 still reads 1.
- R4: After the wake flag is set, the next 1-to-0 transition of `rx` ends sleep: control bit 0 reads 0 after that edge.
- R5: While asleep, writes to the status register, writes to the config register and writes to control bit 1 have no effect.
- R6: While asleep, a write of 0 to control bit 0 ends sleep on that clock edge. A later write of 1 to status bit 5 then clears the flag and `wake_irq`.
- R7: With control bit 1 clear, `rx` edges during sleep neither set the flag nor end sleep. Only a software write ends sleep.
- R8: If `clk_en` is low when the first wake edge arrives, the flag is set, and sleep ends on the first clock edge with `clk_en` high, with no further `rx` edge.
- R9: If `rx` is held at 0 after the first wake edge, sleep persists until software clears it.
- R10: Status bit 5 is write-1-to-clear. Writing 0 to it leaves it set.
- R11: Register writes made while `clk_en` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Controller clock enable; low models a gated controller clock |
| rx | input | 1 | Synchronised receive line, 1 = recessive, 0 = dominant |
| wr | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 status, 2 config |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| wake_irq | output | 1 | Wakeup interrupt, high while status bit 5 is set |

## Verification
The bench targets the dead window between the first and the second dominant edge. It checks that a flag-clear write made there is ignored; a design that woke on the first edge would clear the flag too early. It holds `rx` low after the wake edge to show that sleep persists, which catches a design that wakes on a dominant level instead of a transition. It gates the clock across the wake edge, where a design that still demanded a second edge would stay asleep. It also requests sleep while the line is dominant, where a design with no recessive-line guard would enter sleep.

// File: rtl/can_sleep_wake.sv
module can_sleep_wake #(
  parameter int AW       = 2,
  parameter int DW       = 8,
  parameter int WAKE_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          rx,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          wake_irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_CFG  = AW'(2);

  logic          rx_q, sleep_q, pend_q, offclk_q, bus_en_q, wake_flag_q;
  logic [DW-1:0] cfg_q;

  wire fall       = rx_q & ~rx;
  wire wr_ok      = wr & clk_en;
  wire wr_ctrl    = wr_ok & (addr == A_CTRL);
  wire sw_wake    = wr_ctrl & sleep_q & ~wdata[0];
  wire first_edge = sleep_q & bus_en_q & fall & ~pend_q;
  wire resume     = sleep_q & pend_q & clk_en & (fall | offclk_q);
  wire awake_wr   = wr_ok & ~sleep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sleep_q  <= 1'b0;
      pend_q   <= 1'b0;
      offclk_q <= 1'b0;
    end else if (sw_wake || resume) begin
      sleep_q  <= 1'b0;
      pend_q   <= 1'b0;
      offclk_q <= 1'b0;
    end else if (first_edge) begin
      pend_q   <= 1'b1;
      offclk_q <= ~clk_en;
    end else if (awake_wr && addr == A_CTRL && wdata[0] && rx) begin
      sleep_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              bus_en_q <= 1'b0;
    else if (awake_wr && addr == A_CTRL)     bus_en_q <= wdata[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              wake_flag_q <= 1'b0;
    else if (first_edge)                     wake_flag_q <= 1'b1;
    else if (awake_wr && addr == A_STAT && wdata[WAKE_BIT])
                                             wake_flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              cfg_q <= '0;
    else if (awake_wr && addr == A_CFG)      cfg_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  begin rdata[0] = sleep_q; rdata[1] = bus_en_q; end
      A_STAT:  rdata[WAKE_BIT] = wake_flag_q;
      A_CFG:   rdata = cfg_q;
      default: rdata = '0;
    endcase
  end

  assign wake_irq = wake_flag_q;
endmodule

// File: rtl/can_sleep_wake_chk.sv
module can_sleep_wake_chk #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          rx,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          sleep_q,
  input logic          wake_flag_q,
  input logic          bus_en_q
);
  // R2: no sleep entry on a dominant line
  a_r2_entry_needs_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && wr && addr == AW'(0) && wdata[0] && !sleep_q && !rx) |=> !sleep_q);

  // R3: flag rises while sleep is still in force
  a_r3_flag_keeps_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag_q) |-> sleep_q);

  // R5: flag cannot be cleared during sleep
  a_r5_flag_held_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && wake_flag_q) |=> wake_flag_q);

  // R6: software clear ends sleep on the write edge
  a_r6_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && wr && addr == AW'(0) && !wdata[0] && sleep_q) |=> !sleep_q);

  // R7: no flag without bus wake enable
  a_r7_no_flag_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en_q && !wake_flag_q) |=> !wake_flag_q);
endmodule

bind can_sleep_wake can_sleep_wake_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .rx(rx), .wr(wr), .addr(addr),
  .wdata(wdata), .sleep_q(sleep_q), .wake_flag_q(wake_flag_q), .bus_en_q(bus_en_q)
);

// File: tb/test_can_sleep_wake.sv
module test_can_sleep_wake;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1, rx = 1'b1, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wake_irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  can_sleep_wake i_can_sleep_wake (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .rx(rx), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wake_irq(wake_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic set_rx(input logic v);
    rx = v; @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
    rd(0, d); check("R1 ctrl", d, 8'h00);
    rd(1, d); check("R1 stat", d, 8'h00);
    rd(2, d); check("R1 cfg", d, 8'h00);
    check("R1 irq", {7'b0, wake_irq}, 8'h00);
  endtask

  task automatic t_entry_blocked;
    logic [7:0] d;
    set_rx(1'b0);
    wr_reg(0, 8'h03);
    rd(0, d); check("R2 dominant entry", d, 8'h02);
    set_rx(1'b1);
    wr_reg(0, 8'h00);
  endtask

  task automatic t_two_edge;
    logic [7:0] d;
    wr_reg(0, 8'h03);
    rd(0, d); check("R2 recessive entry", d, 8'h03);
    set_rx(1'b0);
    rd(1, d); check("R3 flag", d, 8'h20);
    check("R3 irq", {7'b0, wake_irq}, 8'h01);
    rd(0, d); check("R3 still asleep", d, 8'h03);
    wr_reg(1, 8'h20);
    rd(1, d); check("R5 clear ignored", d, 8'h20);
    wr_reg(2, 8'h5A);
    rd(2, d); check("R5 cfg ignored", d, 8'h00);
    wr_reg(0, 8'h01);
    rd(0, d); check("R5 ctrl bit1 ignored", d, 8'h03);
    set_rx(1'b1);
    set_rx(1'b0);
    rd(0, d); check("R4 second edge wakes", d, 8'h02);
    wr_reg(1, 8'h00);
    rd(1, d); check("R10 write 0 keeps", d, 8'h20);
    wr_reg(1, 8'h20);
    rd(1, d); check("R10 W1C", d, 8'h00);
    wr_reg(2, 8'h5A);
    rd(2, d); check("R5 cfg awake", d, 8'h5A);
    set_rx(1'b1);
  endtask

  task automatic t_gated_write;
    logic [7:0] d;
    clk_en = 1'b0;
    wr_reg(2, 8'h33);
    clk_en = 1'b1;
    rd(2, d); check("R11 gated write", d, 8'h5A);
  endtask

  task automatic t_sw_clear;
    logic [7:0] d;
    wr_reg(0, 8'h03);
    set_rx(1'b0);
    wr_reg(0, 8'h02);
    rd(0, d); check("R6 sw clear", d, 8'h02);
    wr_reg(1, 8'h20);
    rd(1, d); check("R6 flag cleared", d, 8'h00);
    check("R6 irq low", {7'b0, wake_irq}, 8'h00);
    set_rx(1'b1);
  endtask

  task automatic t_stuck;
    logic [7:0] d;
    wr_reg(0, 8'h03);
    set_rx(1'b0);
    cyc(20);
    rd(0, d); check("R9 stuck dominant", d, 8'h03);
    wr_reg(0, 8'h02);
    rd(0, d); check("R9 sw clear", d, 8'h02);
    wr_reg(1, 8'h20);
    set_rx(1'b1);
  endtask

  task automatic t_bus_off;
    logic [7:0] d;
    wr_reg(0, 8'h01);
    set_rx(1'b0); set_rx(1'b1); set_rx(1'b0);
    rd(1, d); check("R7 no flag", d, 8'h00);
    rd(0, d); check("R7 still asleep", d, 8'h01);
    wr_reg(0, 8'h00);
    rd(0, d); check("R7 sw wake", d, 8'h00);
    set_rx(1'b1);
  endtask

  task automatic t_clk_off;
    logic [7:0] d;
    wr_reg(0, 8'h03);
    clk_en = 1'b0;
    set_rx(1'b0);
    cyc(3);
    rd(1, d); check("R8 flag while gated", d, 8'h20);
    rd(0, d); check("R8 asleep while gated", d, 8'h03);
    clk_en = 1'b1;
    @(negedge clk);
    rd(0, d); check("R8 wake on resume", d, 8'h02);
    wr_reg(1, 8'h20);
    rd(1, d); check("R8 flag cleared", d, 8'h00);
    set_rx(1'b1);
  endtask

  initial begin
    cyc(1);
    t_reset();
    t_entry_blocked();
    t_two_edge();
    t_gated_write();
    t_sw_clear();
    t_stuck();
    t_bus_off();
    t_clk_off();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule